// File: doc/BRIEF.md
# Conditional Move Unit with Dual-Width Flags

This block performs the register-select step of a move-on-condition instruction in a 64-bit integer pipeline. Each issued operation carries the instruction's low 19 bits. These bits hold a 4-bit condition code, a selector that picks either the flags derived from the low 32 bits of a result or the flags derived from all 64 bits, and a source choice. The source is either the second register operand or a sign-extended 11-bit immediate.

The block tests the chosen condition against the chosen flag set. One clock later it presents the new destination value and a write strobe. When the condition fails, the old destination value passes through unchanged and no write is requested. Encodings that are not valid raise an illegal indication and suppress the write.

A second, independent path produces both flag sets for the result of a logical operation. In both sets the carry and overflow bits are cleared. These flags are registered whenever that path is enabled and held at all other times. The register file and the ALU sit outside the block.

Top module: `cmov_flag_unit`

## Requirements
- R1: Field positions in `ins_f`: the condition code is bits 17:14, the integer-flags bit is 18, the flag-set selector is bits 12:11, the source bit is 13, the immediate is bits 10:0, and the must-be-zero field is bits 10:5 when the source bit is 0.
- R2: Flags are 4-bit vectors with N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. The conditions are as follows. Code 8 is always true and code 0 is never true. 9 is !Z and 1 is Z. 10 is !(Z|(N^V)) and 2 is Z|(N^V). 11 is !(N^V) and 3 is N^V. 12 is !(C|Z) and 4 is C|Z. 13 is !C and 5 is C. 14 is !N and 6 is N. 15 is !V and 7 is V.
- R3: Selector value 0 tests `icc_in` and selector value 2 tests `xcc_in`. The flag set that is not selected has no influence on the outcome.
- R4: With the source bit at 1, the moved value is the 11-bit immediate sign-extended to 64 bits. With the source bit at 0, the moved value is `rs2_val`.
- R5: One cycle after a legal `op_valid` whose condition holds, `rd_we` is 1 and `rd_new` is the source value. If the condition fails, `rd_we` is 0 and `rd_new` equals the `rd_old` given with the operation.
- R6: An operation with bit 18 at 0, or with selector value 1 or 3, gives `illegal`=1 and `rd_we`=0 one cycle later, and `rd_new` equals `rd_old`.
- R7: An operation with the source bit at 0 and any of bits 10:5 set is illegal and behaves as in R6.
- R8: One cycle after `logic_valid`, `icc_new` has N equal to bit 31 of `logic_res` and Z equal to (bits 31:0 == 0). `xcc_new` has N equal to bit 63 and Z equal to (all 64 bits == 0). C and V are 0 in both sets. Without `logic_valid`, both flag outputs hold their values.
- R9: One cycle after a cycle in which `op_valid` is 0, `rd_we` and `illegal` are 0 and `rd_new` holds its previous value.
- R10: While reset is applied, and until the first operation after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A move operation is presented this cycle |
| ins_f | input | 19 | Instruction bits 18:0 |
| rs2_val | input | 64 | Second register operand |
| rd_old | input | 64 | Current destination value |
| icc_in | input | 4 | Flags from the low 32 bits {N,Z,V,C} |
| xcc_in | input | 4 | Flags from all 64 bits {N,Z,V,C} |
| logic_valid | input | 1 | Logical result present for flag generation |
| logic_res | input | 64 | Logical result |
| rd_new | output | 64 | Destination value to write |
| rd_we | output | 1 | Destination write strobe |
| illegal | output | 1 | Operation encoding not valid |
| icc_new | output | 4 | Generated low-32 flags |
| xcc_new | output | 4 | Generated 64-bit flags |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath, a 32-bit low flag width and an 11-bit immediate. With these values the 32-versus-64-bit split is visible, so results whose upper half alone is nonzero or negative separate the two Z and N bits. The same values make the immediate sign bit at bit 10 reachable. Every condition code is run against all sixteen flag patterns through both selector values, with the unselected set driven to the complement. This exposes any swap between the two flag sets.

// File: rtl/cmov_pkg.sv
package cmov_pkg;

  // Flag vector layout: N at bit 3, Z at bit 2, V at bit 1, C at bit 0.
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  // Positions of the fields inside the instruction bits.
  localparam int unsigned FLD_W      = 19;
  localparam int unsigned COND_LSB   = 14;
  localparam int unsigned COND_W     = 4;
  localparam int unsigned INT_CC_BIT = 18;
  localparam int unsigned SRC_BIT    = 13;
  localparam int unsigned SEL_LSB    = 11;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned RES_LSB    = 5;

  // Results of decoding one operation.
  typedef struct packed {
    logic [COND_W-1:0] cond;
    logic              sel_full;
    logic              use_imm;
    logic              legal;
  } dec_t;

endpackage

// File: rtl/cmov_rst_sync.sv
module cmov_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  // Assertion is asynchronous; release passes through STAGES flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cmov_decode.sv
module cmov_decode
  import cmov_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 11
) (
  input  logic [FLD_W-1:0] ins_f,
  output dec_t             dec,
  output logic [XLEN-1:0]  imm_ext
);
  localparam int unsigned RES_W = IMM_W - RES_LSB;
  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [SEL_W-1:0] sel;
  logic [RES_W-1:0] rsvd;
  logic [IMM_W-1:0] imm;
  logic             int_cc;

  always_comb begin
    sel    = ins_f[SEL_LSB +: SEL_W];
    rsvd   = ins_f[RES_LSB +: RES_W];
    imm    = ins_f[IMM_W-1:0];
    int_cc = ins_f[INT_CC_BIT];

    dec.cond     = ins_f[COND_LSB +: COND_W];
    dec.use_imm  = ins_f[SRC_BIT];
    dec.sel_full = sel[1];
    // Legal only with integer codes, an even selector, and a clear
    // must-be-zero field whenever the register source is used.
    dec.legal    = int_cc && !sel[0] && (dec.use_imm || (rsvd == '0));

    imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  end
endmodule

// File: rtl/cmov_cond_eval.sv
module cmov_cond_eval
  import cmov_pkg::*;
(
  input  ccr_t              flags,
  input  logic [COND_W-1:0] cond,
  output logic              taken
);
  logic lt_s;
  logic base;

  // The upper code bit inverts one of eight base tests.
  always_comb begin
    lt_s = flags.n ^ flags.v;
    unique case (cond[COND_W-2:0])
      3'd0:    base = 1'b0;
      3'd1:    base = flags.z;
      3'd2:    base = flags.z | lt_s;
      3'd3:    base = lt_s;
      3'd4:    base = flags.c | flags.z;
      3'd5:    base = flags.c;
      3'd6:    base = flags.n;
      default: base = flags.v;
    endcase
    taken = base ^ cond[COND_W-1];
  end
endmodule

// File: rtl/cmov_flag_gen.sv
module cmov_flag_gen
  import cmov_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LOW_W = 32
) (
  input  logic [XLEN-1:0] res,
  output ccr_t            low_f,
  output ccr_t            full_f
);
  ccr_t sets [2];

  // Index 0 covers the low part; index 1 covers the full width.
  for (genvar g = 0; g < 2; g++) begin : g_set
    localparam int unsigned W = (g == 0) ? LOW_W : XLEN;
    always_comb begin
      sets[g].n = res[W-1];
      sets[g].z = (res[W-1:0] == '0);
      sets[g].v = 1'b0;
      sets[g].c = 1'b0;
    end
  end

  assign low_f  = sets[0];
  assign full_f = sets[1];
endmodule

// File: rtl/cmov_flag_unit.sv
module cmov_flag_unit
  import cmov_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LOW_W = 32,
  parameter int unsigned IMM_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [FLD_W-1:0]  ins_f,
  input  logic [XLEN-1:0]   rs2_val,
  input  logic [XLEN-1:0]   rd_old,
  input  logic [3:0]        icc_in,
  input  logic [3:0]        xcc_in,
  input  logic              logic_valid,
  input  logic [XLEN-1:0]   logic_res,
  output logic [XLEN-1:0]   rd_new,
  output logic              rd_we,
  output logic              illegal,
  output logic [3:0]        icc_new,
  output logic [3:0]        xcc_new
);
  logic            rst_sync_n;
  dec_t            dec;
  logic [XLEN-1:0] imm_ext;
  ccr_t            sel_flags;
  logic            taken;
  ccr_t            gen_low, gen_full;

  logic [XLEN-1:0] rd_d, rd_q;
  logic            we_d, we_q;
  logic            ill_d, ill_q;
  ccr_t            icc_q, xcc_q;

  cmov_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmov_decode #(.XLEN(XLEN), .IMM_W(IMM_W)) u_dec (
    .ins_f   (ins_f),
    .dec     (dec),
    .imm_ext (imm_ext)
  );

  assign sel_flags = dec.sel_full ? ccr_t'(xcc_in) : ccr_t'(icc_in);

  cmov_cond_eval u_cond (
    .flags (sel_flags),
    .cond  (dec.cond),
    .taken (taken)
  );

  cmov_flag_gen #(.XLEN(XLEN), .LOW_W(LOW_W)) u_fgen (
    .res    (logic_res),
    .low_f  (gen_low),
    .full_f (gen_full)
  );

  // Next-state logic for the move path.
  always_comb begin
    we_d  = op_valid && dec.legal && taken;
    ill_d = op_valid && !dec.legal;
    rd_d  = we_d ? (dec.use_imm ? imm_ext : rs2_val) : rd_old;
  end

  // Strobes are refreshed every cycle; data registers use enables.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      we_q  <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      we_q  <= we_d;
      ill_q <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   rd_q <= '0;
    else if (op_valid) rd_q <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      icc_q <= '0;
      xcc_q <= '0;
    end else if (logic_valid) begin
      icc_q <= gen_low;
      xcc_q <= gen_full;
    end
  end

  assign rd_new  = rd_q;
  assign rd_we   = we_q;
  assign illegal = ill_q;
  assign icc_new = icc_q;
  assign xcc_new = xcc_q;
endmodule

// File: rtl/cmov_flag_unit_chk.sv
module cmov_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [18:0] ins_f,
  input logic [63:0] rd_old,
  input logic        logic_valid,
  input logic [63:0] logic_res,
  input logic [63:0] rd_new,
  input logic        rd_we,
  input logic        illegal,
  input logic [3:0]  icc_new,
  input logic [3:0]  xcc_new
);
  AST_WE_EXCLUDES_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> !illegal); // R6

  AST_NONINT_CC_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ins_f[18]) |=> (illegal && !rd_we)); // R6

  AST_ODD_SEL_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ins_f[11]) |=> (illegal && !rd_we)); // R6

  AST_RSVD_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ins_f[13] && (ins_f[10:5] != 6'd0)) |=> illegal); // R7

  AST_NEVER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ins_f[17:14] == 4'd0) |=> !rd_we); // R2

  AST_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ins_f[17:14] == 4'd8 && ins_f[18] && ins_f[12:11] != 2'd1 &&
     ins_f[12:11] != 2'd3 && (ins_f[13] || ins_f[10:5] == 6'd0)) |=> rd_we); // R2

  AST_NOWRITE_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (rd_we || rd_new == $past(rd_old))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!rd_we && !illegal && $stable(rd_new))); // R9

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !logic_valid |=> ($stable(icc_new) && $stable(xcc_new))); // R8

  AST_UPPER_ZERO_SAME_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_valid && logic_res[63:32] == 32'd0) |=> (xcc_new[2] == icc_new[2])); // R8

  AST_CV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    logic_valid |=> (icc_new[1:0] == 2'b00 && xcc_new[1:0] == 2'b00)); // R8
endmodule

bind cmov_flag_unit cmov_flag_unit_chk chk_i (.*);

// File: tb/cmov_flag_unit_tb.sv
module cmov_flag_unit_tb_top;
  localparam realtime HALF = 4ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [18:0] ins_f;
  logic [63:0] rs2_val, rd_old;
  logic [3:0]  icc_in, xcc_in;
  logic        logic_valid;
  logic [63:0] logic_res;
  logic [63:0] rd_new;
  logic        rd_we, illegal;
  logic [3:0]  icc_new, xcc_new;

  always #HALF clk = ~clk;

  cmov_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .ins_f(ins_f),
    .rs2_val(rs2_val), .rd_old(rd_old), .icc_in(icc_in), .xcc_in(xcc_in),
    .logic_valid(logic_valid), .logic_res(logic_res), .rd_new(rd_new),
    .rd_we(rd_we), .illegal(illegal), .icc_new(icc_new), .xcc_new(xcc_new)
  );

  typedef struct {
    int          cyc;
    logic [63:0] rd;
    logic        we;
    logic        ill;
    logic [3:0]  icc;
    logic [3:0]  xcc;
    string       req;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   done = 0;

  logic [63:0] m_rd  = '0;
  logic [3:0]  m_icc = '0;
  logic [3:0]  m_xcc = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit cond_true(input logic [3:0] c, input logic [3:0] f);
    logic n, z, v, cf;
    {n, z, v, cf} = f;
    case (c)
      4'd0:  return 1'b0;
      4'd1:  return z;
      4'd2:  return z | (n ^ v);
      4'd3:  return n ^ v;
      4'd4:  return cf | z;
      4'd5:  return cf;
      4'd6:  return n;
      4'd7:  return v;
      4'd8:  return 1'b1;
      4'd9:  return !z;
      4'd10: return !(z | (n ^ v));
      4'd11: return !(n ^ v);
      4'd12: return !(cf | z);
      4'd13: return !cf;
      4'd14: return !n;
      default: return !v;
    endcase
  endfunction

  function automatic logic [18:0] mk(input bit icb, input logic [3:0] c,
                                     input bit src, input logic [1:0] sel,
                                     input logic [10:0] low);
    return {icb, c, src, sel, low};
  endfunction

  // Monitor: compares one cycle after each driven cycle.
  always @(posedge clk) begin
    cyc++;
    #2;
    if (sbq.size() > 0 && sbq[0].cyc == cyc - 1) begin
      exp_t e;
      e = sbq.pop_front();
      chk(rd_we == e.we, e.req, "rd_we", 64'(rd_we), 64'(e.we));
      chk(illegal == e.ill, e.req, "illegal", 64'(illegal), 64'(e.ill));
      chk(rd_new == e.rd, e.req, "rd_new", rd_new, e.rd);
      chk(icc_new == e.icc, e.req, "icc_new", 64'(icc_new), 64'(e.icc));
      chk(xcc_new == e.xcc, e.req, "xcc_new", 64'(xcc_new), 64'(e.xcc));
    end
  end

  // Driver: one cycle of stimulus, expected item pushed to the queue.
  task automatic drive(input bit v, input logic [18:0] ins, input logic [63:0] r2,
                       input logic [63:0] old, input logic [3:0] ic, input logic [3:0] xc,
                       input bit lv, input logic [63:0] lr, input string req);
    exp_t e;
    bit legal, tk;
    logic [63:0] src;
    @(negedge clk);
    op_valid = v; ins_f = ins; rs2_val = r2; rd_old = old;
    icc_in = ic; xcc_in = xc; logic_valid = lv; logic_res = lr;
    legal = ins[18] && !ins[11] && (ins[13] || ins[10:5] == 6'd0);
    tk = cond_true(ins[17:14], ins[12] ? xc : ic);
    src = ins[13] ? {{53{ins[10]}}, ins[10:0]} : r2;
    e.we = 0; e.ill = 0;
    if (v) begin
      e.we  = legal && tk;
      e.ill = !legal;
      m_rd  = e.we ? src : old;
    end
    if (lv) begin
      m_icc = {lr[31], lr[31:0] == 32'd0, 2'b00};
      m_xcc = {lr[63], lr == 64'd0, 2'b00};
    end
    e.rd = m_rd; e.icc = m_icc; e.xcc = m_xcc;
    e.cyc = cyc; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic idle(input string req);
    drive(0, 19'h7FFFF, 64'hDEAD, 64'hBEEF, 4'hF, 4'hF, 0, 64'h1, req);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_valid = 0; ins_f = '0; rs2_val = '0; rd_old = '0;
    icc_in = '0; xcc_in = '0; logic_valid = 0; logic_res = '0;
    repeat (3) @(negedge clk);
    chk(rd_new == 0 && !rd_we && !illegal && icc_new == 0 && xcc_new == 0,
        "R10", "outputs in reset", {rd_new[59:0], icc_new}, 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(rd_new == 0 && !rd_we && !illegal && icc_new == 0 && xcc_new == 0,
        "R10", "outputs after release", {rd_new[59:0], icc_new}, 64'd0);

    // R1 R2 R3 R5: every code against every flag pattern, both selectors.
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        drive(1, mk(1, 4'(c), 0, 2'd0, 11'd0), 64'(c * 1000 + f + 1),
              64'hA000 + 64'(f), 4'(f), ~4'(f), 0, 0, "R2 R3 R5 icc");
        drive(1, mk(1, 4'(c), 0, 2'd2, 11'd0), 64'(c * 2000 + f + 7),
              64'hB000 + 64'(f), ~4'(f), 4'(f), 0, 0, "R2 R3 R5 xcc");
      end
    end

    // R4: immediate source with sign extension.
    drive(1, mk(1, 4'd8, 1, 2'd0, 11'h3FF), 64'h55, 64'h66, 0, 0, 0, 0, "R4 imm pos");
    drive(1, mk(1, 4'd8, 1, 2'd2, 11'h400), 64'h55, 64'h66, 0, 0, 0, 0, "R4 imm neg");
    drive(1, mk(1, 4'd8, 1, 2'd0, 11'h7FF), 64'h55, 64'h66, 0, 0, 0, 0, "R4 imm -1");
    drive(1, mk(1, 4'd8, 0, 2'd0, 11'h01F), 64'hCAFE_F00D_1234_5678, 64'h66, 0, 0, 0, 0, "R4 R1 rs2");
    drive(1, mk(1, 4'd0, 1, 2'd0, 11'h400), 64'h55, 64'h777, 0, 0, 0, 0, "R4 R5 imm untaken");

    // R6 R7: illegal encodings.
    drive(1, mk(0, 4'd8, 0, 2'd0, 11'd0), 64'h11, 64'h22, 0, 0, 0, 0, "R6 non-int");
    drive(1, mk(1, 4'd8, 0, 2'd1, 11'd0), 64'h11, 64'h23, 0, 0, 0, 0, "R6 sel1");
    drive(1, mk(1, 4'd8, 1, 2'd3, 11'd5), 64'h11, 64'h24, 0, 0, 0, 0, "R6 sel3");
    drive(1, mk(1, 4'd8, 0, 2'd0, 11'h020), 64'h11, 64'h25, 0, 0, 0, 0, "R7 rsvd low");
    drive(1, mk(1, 4'd8, 0, 2'd2, 11'h400), 64'h11, 64'h26, 0, 0, 0, 0, "R7 rsvd high");
    drive(1, mk(1, 4'd8, 1, 2'd0, 11'h7E0), 64'h11, 64'h27, 0, 0, 0, 0, "R7 imm ok");

    // R9: idle cycles hold rd_new and clear strobes.
    idle("R9 idle");
    idle("R9 idle");

    // R8: logical flag generation, with and without a move alongside.
    drive(0, 0, 0, 0, 0, 0, 1, 64'd0, "R8 zero");
    drive(0, 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_0000_0000, "R8 upper only");
    drive(0, 0, 0, 0, 0, 0, 1, 64'h0000_0000_8000_0000, "R8 low neg");
    drive(0, 0, 0, 0, 0, 0, 1, 64'h0000_0001_0000_0000, "R8 upper bit");
    drive(1, mk(1, 4'd9, 0, 2'd0, 0), 64'h99, 64'h98, 4'h0, 4'h4, 1, 64'h8000_0000_0000_0001, "R8 R5 both");
    idle("R8 hold");
    idle("R8 hold");

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R5", "scoreboard drained", 64'(sbq.size()), 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule